// File: doc/BRIEF.md
# Pulse-Evaluated Stateful Reconfigurable Gate

This block is a clocked behavioural model of a reconfigurable logic gate whose output is a held state bit rather than a combinational function. A bank of data inputs and two configuration bits choose among four functions of the inputs: AND, OR, NOR and NAND. The state only moves during an evaluate strobe, and only when a thresholded drive pushes it away from its present value. Without a strobe, the state stays where it is for as long as needed.

The drive is modelled as a vote. Each data input has weight one. The family bit adds a weight of one less than the input count, either to the drive that sets the state or to the drive that clears it. A drive switches the state only when the vote reaches the input count. A parameter chooses how the state is driven. In reset-evaluate style, a clear phase first forces the state to 0, and an evaluate strobe can then only set it to 1. In feedback style, each evaluate strobe enables only the drive path that opposes the present output. A counter records every cycle in which a drive switches or forces the state, so the two styles can be compared for the same input pattern.

Top module: `reconfig_hold_gate`

## Requirements
- R1: While rstN is low, and on the first sampled cycle after it rises, gateOut is 0 and driveCount is 0.
- R2: With cfgFamily=0 and cfgInvert=0 in feedback style, gateOut after an evaluate cycle equals the AND of all dataIn bits.
- R3: With cfgFamily=1 and cfgInvert=0 in feedback style, gateOut after an evaluate cycle equals the OR of the dataIn bits.
- R4: cfgInvert=1 inverts every dataIn bit before the vote. The result is NOR when cfgFamily=0 and NAND when cfgFamily=1.
- R5: In a cycle with evalPulse low, gateOut and driveCount keep their values whatever dataIn, cfgFamily and cfgInvert do. In reset-evaluate style this holds only while clearPhase is also low.
- R6: In feedback style, driveCount rises by exactly 1 on each evaluate cycle that changes gateOut. It does not change when the evaluated function already equals gateOut.
- R7: A drive below the threshold leaves the state unchanged. For example, with AND selected and state 0, three of four inputs high give no change and no count.
- R8: In reset-evaluate style, a cycle with clearPhase high and evalPulse low forces gateOut to 0 and adds 1 to driveCount, even if the state was already 0.
- R9: In reset-evaluate style, an evaluate cycle with clearPhase low sets gateOut to 1 and adds 1 to driveCount when the selected function is true. Otherwise it leaves both unchanged, so it never clears the state.
- R10: In feedback style, clearPhase has no effect.
- R11: In reset-evaluate style, a cycle with both clearPhase and evalPulse high changes neither gateOut nor driveCount.
- R12: driveCount changes by at most 1 per cycle and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | NUM_IN | Data inputs |
| cfgFamily | input | 1 | 0 selects the AND family, 1 selects the OR family |
| cfgInvert | input | 1 | 1 inverts the data inputs before the vote |
| clearPhase | input | 1 | Clear-phase strobe, used in reset-evaluate style only |
| evalPulse | input | 1 | Evaluate strobe |
| gateOut | output | 1 | Held state of the gate |
| driveCount | output | CNT_W | Number of drive events |

## Verification
Every result is due one clock after the cycle that samples the strobes. The state register and the counter both update on the same edge, and no output has extra latency. The bench changes inputs on the falling edge and lets the rising edge sample them. It then advances its behavioural models of both styles, and compares gateOut and driveCount of one instance of each style on the next falling edge. Because no stimulus is still pending at that point, each comparison sees exactly the effect of the one cycle just applied.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;
  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic forceClear; // unconditional drive towards 0
    logic trySet;     // thresholded drive towards 1
    logic tryClear;   // thresholded drive towards 0
  } gate_strobe_t;
endpackage

// File: rtl/hold_gate_ctrl.sv
module hold_gate_ctrl #(
  parameter bit FEEDBACK_MODE = 1'b1
) (
  input  logic clearPhase,
  input  logic evalPulse,
  input  logic gateState,
  output hold_gate_pkg::gate_strobe_t strobes
);
  always_comb begin
    if (FEEDBACK_MODE) begin
      // Only the path that opposes the present state is enabled
      strobes.forceClear = 1'b0;
      strobes.trySet     = evalPulse & ~gateState;
      strobes.tryClear   = evalPulse & gateState;
    end else begin
      // Clear phase, then a set-only evaluation; both at once do nothing
      strobes.forceClear = clearPhase & ~evalPulse;
      strobes.trySet     = evalPulse & ~clearPhase;
      strobes.tryClear   = 1'b0;
    end
  end
endmodule

// File: rtl/hold_gate_datapath.sv
module hold_gate_datapath #(
  parameter int NUM_IN = 4,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        dataIn,
  input  logic                     cfgFamily,
  input  logic                     cfgInvert,
  input  hold_gate_pkg::gate_strobe_t strobes,
  output logic                     gateState,
  output logic [CNT_W-1:0]         driveCount
);
  localparam int VOTE_W = $clog2(2 * NUM_IN);
  localparam logic [VOTE_W-1:0] THRESH = VOTE_W'(NUM_IN);
  localparam logic [VOTE_W-1:0] WEIGHT = VOTE_W'(NUM_IN - 1);

  function automatic logic [VOTE_W-1:0] popCount(input logic [NUM_IN-1:0] v);
    logic [VOTE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_IN; i++) acc = acc + VOTE_W'(v[i]);
    return acc;
  endfunction

  logic [NUM_IN-1:0] effIn;
  logic [VOTE_W-1:0] setVotes, clrVotes;
  logic setMet, clrMet, nextState, driveActive;

  assign effIn    = cfgInvert ? ~dataIn : dataIn;
  // The family weight joins the set voters, or its complement joins the clear voters
  assign setVotes = popCount(effIn)  + (cfgFamily ? WEIGHT : '0);
  assign clrVotes = popCount(~effIn) + (cfgFamily ? '0 : WEIGHT);
  assign setMet   = setVotes >= THRESH;
  assign clrMet   = clrVotes >= THRESH;

  always_comb begin
    nextState   = gateState;
    driveActive = 1'b0;
    if (strobes.forceClear) begin
      nextState   = 1'b0;
      driveActive = 1'b1;
    end else if (strobes.trySet && setMet) begin
      nextState   = 1'b1;
      driveActive = 1'b1;
    end else if (strobes.tryClear && clrMet) begin
      nextState   = 1'b0;
      driveActive = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateState  <= 1'b0;
      driveCount <= '0;
    end else begin
      gateState <= nextState;
      if (driveActive) driveCount <= driveCount + 1'b1;
    end
  end
endmodule

// File: rtl/reconfig_hold_gate.sv
module reconfig_hold_gate #(
  parameter int NUM_IN        = 4,
  parameter int CNT_W         = 16,
  parameter bit FEEDBACK_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic              cfgFamily,
  input  logic              cfgInvert,
  input  logic              clearPhase,
  input  logic              evalPulse,
  output logic              gateOut,
  output logic [CNT_W-1:0]  driveCount
);
  hold_gate_pkg::gate_strobe_t strobes;

  hold_gate_ctrl #(.FEEDBACK_MODE(FEEDBACK_MODE)) u_ctrl (
    .clearPhase(clearPhase),
    .evalPulse (evalPulse),
    .gateState (gateOut),
    .strobes   (strobes)
  );

  hold_gate_datapath #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .cfgFamily (cfgFamily),
    .cfgInvert (cfgInvert),
    .strobes   (strobes),
    .gateState (gateOut),
    .driveCount(driveCount)
  );
endmodule

// File: rtl/hold_gate_checker.sv
module hold_gate_checker #(
  parameter int NUM_IN        = 4,
  parameter int CNT_W         = 16,
  parameter bit FEEDBACK_MODE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] dataIn,
  input logic              cfgFamily,
  input logic              cfgInvert,
  input logic              clearPhase,
  input logic              evalPulse,
  input logic              gateOut,
  input logic [CNT_W-1:0]  driveCount
);
  logic [NUM_IN-1:0] seen;
  logic fnNow, quiet;
  assign seen  = cfgInvert ? ~dataIn : dataIn;
  assign fnNow = cfgFamily ? (|seen) : (&seen);
  assign quiet = !evalPulse && (FEEDBACK_MODE || !clearPhase);

  AST_HOLD_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> ($stable(gateOut) && $stable(driveCount))); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (driveCount == $past(driveCount) || driveCount == $past(driveCount) + 1'b1)); // R12

  AST_CHANGE_IS_COUNTED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (gateOut == $past(gateOut) || driveCount != $past(driveCount))); // R6

  if (FEEDBACK_MODE) begin : g_fb
    AST_FEEDBACK_FUNCTION: assert property (@(posedge clk) disable iff (!rstN)
      evalPulse |=> gateOut == $past(fnNow)); // R2
  end else begin : g_re
    AST_CLEAR_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (clearPhase && !evalPulse) |=> !gateOut); // R8
    AST_PULSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (evalPulse && !clearPhase && gateOut) |=> gateOut); // R9
    AST_BOTH_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (evalPulse && clearPhase) |=> ($stable(gateOut) && $stable(driveCount))); // R11
  end
endmodule

bind reconfig_hold_gate hold_gate_checker #(
  .NUM_IN(NUM_IN), .CNT_W(CNT_W), .FEEDBACK_MODE(FEEDBACK_MODE)
) u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .cfgFamily(cfgFamily),
  .cfgInvert(cfgInvert), .clearPhase(clearPhase), .evalPulse(evalPulse),
  .gateOut(gateOut), .driveCount(driveCount)
);

// File: tb/test_reconfig_hold_gate.sv
`timescale 1ns/1ps
module test_reconfig_hold_gate;
  localparam int N = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] dataIn = '0;
  logic cfgFamily = 1'b0, cfgInvert = 1'b0, clearPhase = 1'b0, evalPulse = 1'b0;
  logic fbOut, reOut;
  logic [CW-1:0] fbCnt, reCnt;

  int total = 0, bad = 0;
  bit finished = 0;
  // Behavioural reference state for both styles
  int mFbState = 0, mFbCnt = 0, mReState = 0, mReCnt = 0;

  always #4 clk = ~clk;

  reconfig_hold_gate #(.NUM_IN(N), .CNT_W(CW), .FEEDBACK_MODE(1'b1)) i_reconfig_hold_gate (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .cfgFamily(cfgFamily), .cfgInvert(cfgInvert),
    .clearPhase(clearPhase), .evalPulse(evalPulse), .gateOut(fbOut), .driveCount(fbCnt));

  reconfig_hold_gate #(.NUM_IN(N), .CNT_W(CW), .FEEDBACK_MODE(1'b0)) i_reconfig_hold_gate_re (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .cfgFamily(cfgFamily), .cfgInvert(cfgInvert),
    .clearPhase(clearPhase), .evalPulse(evalPulse), .gateOut(reOut), .driveCount(reCnt));

  function automatic int gateFn(input logic [N-1:0] d, input logic fam, input logic inv);
    int ones = 0;
    for (int i = 0; i < N; i++) if ((d[i] ^ inv) == 1'b1) ones++;
    if (fam) return (ones > 0) ? 1 : 0;
    return (ones == N) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "feedback gateOut", int'(fbOut), mFbState);
    check(tag, "feedback driveCount", int'(fbCnt), mFbCnt);
    check(tag, "reset-eval gateOut", int'(reOut), mReState);
    check(tag, "reset-eval driveCount", int'(reCnt), mReCnt);
  endtask

  // Apply one cycle of stimulus, advance the models at the edge, compare after it
  task automatic step(input string tag, input logic [N-1:0] d, input logic fam,
                      input logic inv, input logic clr, input logic pls);
    int f;
    dataIn = d; cfgFamily = fam; cfgInvert = inv; clearPhase = clr; evalPulse = pls;
    @(posedge clk);
    f = gateFn(d, fam, inv);
    if (pls) begin
      if (f != mFbState) begin mFbState = f; mFbCnt++; end
    end
    if (clr && !pls) begin mReState = 0; mReCnt++; end
    else if (pls && !clr && f == 1) begin mReState = 1; mReCnt++; end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    step("R2", 4'b1111, 0, 0, 0, 1);  // AND true: both set
    step("R6", 4'b1111, 0, 0, 0, 1);  // feedback: no drive; reset style counts
    step("R2", 4'b0111, 0, 0, 0, 1);  // feedback clears; reset style holds (R9)
    step("R9", 4'b0111, 0, 0, 0, 1);
    step("R5", 4'b1111, 1, 1, 0, 0);  // inputs and config move without pulse
    step("R5", 4'b0000, 1, 0, 0, 0);
    step("R8", 4'b0000, 0, 0, 1, 0);  // clear phase; feedback ignores it (R10)
    step("R10", 4'b1111, 0, 0, 1, 0);
    step("R7", 4'b1110, 0, 0, 0, 1);  // below threshold
    step("R7", 4'b1011, 0, 0, 0, 1);
    step("R3", 4'b0001, 1, 0, 0, 1);  // OR: one input suffices
    step("R3", 4'b0000, 1, 0, 0, 1);
    step("R8", 4'b0000, 1, 0, 1, 0);
    step("R4", 4'b0000, 0, 1, 0, 1);  // NOR true
    step("R4", 4'b0100, 0, 1, 0, 1);  // NOR false
    step("R4", 4'b1111, 1, 1, 0, 1);  // NAND false
    step("R4", 4'b1011, 1, 1, 0, 1);  // NAND true
    step("R11", 4'b0000, 0, 0, 1, 1); // both strobes
    step("R11", 4'b1111, 0, 0, 1, 1);

    // Sweep every input pattern under every configuration, with periodic clear phases
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 16; v++) begin
        step("R12", 4'(v), c[0], c[1], 0, 1);
        if (v % 5 == 4) step("R8", 4'(v), c[0], c[1], 1, 0);
        if (v % 7 == 3) step("R5", 4'(~v), ~c[0], c[1], 0, 0);
      end
    end
    // Reset-evaluate style must have spent more drive events
    total++;
    if (!(int'(reCnt) > int'(fbCnt))) begin
      bad++;
      $display("FAIL R8 drive totals actual=%0d expected>%0d", reCnt, fbCnt);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule